// File: doc/BRIEF.md
# Cipher Accelerator Register Front-End

This block is the bus side of a block-cipher accelerator. It does not compute the cipher rounds. It holds a 128-bit state and two 128-bit key halves, takes its configuration from a control register, and runs a start/done handshake with an external round engine. Software fills the state and each key half through word-wide ports. Each write shifts one 32-bit word in. The state can also be loaded with XOR-on-write. Software reads the result back from the same data port, one word per read, and each read rotates the state.

An operation starts in one of two ways. Software can issue a start command, or the block can start itself when the fourth consecutive word arrives on a port whose auto-start bit is set. A stop command ends the operation at once. While an operation runs, the block freezes its configuration and its staged operands. A byte-reversal mode reorders the bytes of every 128-bit operand on its way to the engine and restores the order of the result. This mode costs exactly two extra cycles.

Top module: `aes_reg_frontend`

## Requirements
- R1: Control bit 0 (address 0) selects the direction, 0 encrypt and 1 decrypt, and drives `eng_decrypt_o` for the operation.
- R2: Control bit 1 selects the key length. When it is 0, only the low key half reaches the engine, the upper 128 key bits are zero, and the high half has no effect on the result.
- R3: Each write to the data port (address 2) shifts one word in, so after four writes the first word written is word 0. Each read of address 2 returns word 0 and rotates the state down by one word, so four reads return the words in the order they were written.
- R4: A write to the XOR port (address 3) shifts in the written word XORed with the current word 0, so four writes XOR a block into the staged state.
- R5: The low key half is loaded through address 4 and the high half through address 5, each with the same four-word shift as the data port.
- R6: Writing 1 to bit 0 of the command register (address 1) starts an operation when none is running.
- R7: When control bit 2 (data port) or bit 3 (XOR port) is set, the fourth consecutive write to that port starts an operation. A switch between the two ports restarts the count, and with the bit clear no start happens.
- R8: Writing 1 to command bit 1 during an operation aborts it. Running drops on the next cycle, and the staged state keeps the value it had before the start.
- R9: Status bit 0 (address 6), which is also `running_o`, is 1 from the cycle after a start until the cycle after the result is captured. After reset, the control, status and state read as zero.
- R10: When control bit 4 is set, the bytes of each 128-bit operand are reversed for the engine, the result is reversed back on capture, and the operation takes exactly two cycles more.
- R11: While running, writes to the control, data, XOR and key ports are ignored, and data-port reads do not rotate the state.
- R12: `eng_start_o` is a single-cycle pulse. The result is captured into the state on the `eng_done_i` pulse, so with an engine latency of L cycles, running lasts L+1 cycles in normal byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| running_o | output | 1 | Operation in progress |
| eng_start_o | output | 1 | Start pulse to the engine |
| eng_abort_o | output | 1 | Abort pulse to the engine |
| eng_decrypt_o | output | 1 | Direction for the engine |
| eng_key256_o | output | 1 | Key length for the engine |
| eng_state_o | output | 128 | State operand |
| eng_key_o | output | 256 | Key operand, high half on top |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_result_i | input | 128 | Engine result, valid with done |

## Verification
Four properties are checked on every cycle:
- the start pulse lasts exactly one cycle;
- the start pulse only occurs while running;
- running drops on the cycle after a stop command;
- the control register holds steady while running.

The bench scenarios are needed for the rest: word ordering through the shift ports, the XOR loading, the auto-start counting across a port switch, and the result values under each combination of direction, key length and byte order. Exact operation lengths, and state preserved across an abort, are also shown only by the scenarios.

// File: rtl/aes_fe_pkg.sv
package aes_fe_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd2;
  localparam logic [ADDR_W-1:0] A_XOR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_KEYL = 3'd4;
  localparam logic [ADDR_W-1:0] A_KEYH = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd6;

  typedef struct packed {
    logic byte_rev;
    logic xor_auto;
    logic data_auto;
    logic key256;
    logic decrypt;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [2:0] {
    S_IDLE, S_SW1, S_SW2, S_LAUNCH, S_WAIT
  } seq_e;
endpackage

// File: rtl/aes_fe_shreg.sv
module aes_fe_shreg #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  localparam int W = WORD_W * NWORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [W-1:0]      cap_d_i,
  input  logic              load_i,
  input  logic              xor_i,
  input  logic              rot_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [W-1:0]      q_o
);
  logic [W-1:0]      q_q;
  logic [WORD_W-1:0] in_word;

  assign in_word = xor_i ? (word_i ^ q_q[WORD_W-1:0]) : word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (cap_i)  q_q <= cap_d_i;
    else if (load_i) q_q <= {in_word, q_q[W-1:WORD_W]};
    else if (rot_i)  q_q <= {q_q[WORD_W-1:0], q_q[W-1:WORD_W]};
  end

  assign q_o = q_q;
endmodule

// File: rtl/aes_fe_seq.sv
module aes_fe_seq
  import aes_fe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic stop_i,
  input  logic byte_rev_i,
  input  logic done_i,
  output logic running_o,
  output logic launch_o,
  output logic capture_o
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (go_i) st_d = byte_rev_i ? S_SW1 : S_LAUNCH;
      S_SW1:    st_d = S_SW2;
      S_SW2:    st_d = S_LAUNCH;
      S_LAUNCH: st_d = S_WAIT;
      S_WAIT:   if (done_i) st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
    if (stop_i && st_q != S_IDLE) st_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  assign running_o = (st_q != S_IDLE);
  assign launch_o  = (st_q == S_LAUNCH) && !stop_i;
  assign capture_o = (st_q == S_WAIT) && done_i && !stop_i;
endmodule

// File: rtl/aes_reg_frontend.sv
module aes_reg_frontend
  import aes_fe_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  localparam int BLK_W = WORD_W * NWORDS,
  localparam int CNT_W = $clog2(NWORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               running_o,
  output logic               eng_start_o,
  output logic               eng_abort_o,
  output logic               eng_decrypt_o,
  output logic               eng_key256_o,
  output logic [BLK_W-1:0]   eng_state_o,
  output logic [2*BLK_W-1:0] eng_key_o,
  input  logic               eng_done_i,
  input  logic [BLK_W-1:0]   eng_result_i
);
  function automatic logic [BLK_W-1:0] rev_bytes(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] r;
    for (int i = 0; i < BLK_W / 8; i++) r[8*i +: 8] = x[BLK_W-8-8*i +: 8];
    return r;
  endfunction

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_xor_q;
  logic             running, capture;
  logic             wr_ok, wr_data, wr_xor, wr_shift, same_port, fourth;
  logic             cmd_go, auto_go, stop;
  logic [BLK_W-1:0] state_q, keyl_q, keyh_q, cap_d;

  assign wr_ok    = wr_en_i && !running;
  assign wr_data  = wr_ok && addr_i == A_DATA;
  assign wr_xor   = wr_ok && addr_i == A_XOR;
  assign wr_shift = wr_data || wr_xor;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ctrl_q <= '0;
    else if (wr_ok && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  // consecutive-write count; a port switch restarts it
  assign same_port = (cnt_q == '0) || (wr_xor == last_xor_q);
  assign fourth    = wr_shift && same_port && (cnt_q == CNT_W'(NWORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      last_xor_q <= 1'b0;
    end else if (wr_shift) begin
      last_xor_q <= wr_xor;
      if (fourth)         cnt_q <= '0;
      else if (same_port) cnt_q <= cnt_q + 1'b1;
      else                cnt_q <= CNT_W'(1);
    end
  end

  assign auto_go = fourth && (wr_xor ? ctrl_q.xor_auto : ctrl_q.data_auto);
  assign cmd_go  = wr_ok && addr_i == A_CMD && wdata_i[0];
  assign stop    = wr_en_i && addr_i == A_CMD && wdata_i[1] && running;

  aes_fe_seq u_seq (
    .clk_i, .rst_ni,
    .go_i       (cmd_go || auto_go),
    .stop_i     (stop),
    .byte_rev_i (ctrl_q.byte_rev),
    .done_i     (eng_done_i),
    .running_o  (running),
    .launch_o   (eng_start_o),
    .capture_o  (capture)
  );

  assign cap_d = ctrl_q.byte_rev ? rev_bytes(eng_result_i) : eng_result_i;

  aes_fe_shreg #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_state (
    .clk_i, .rst_ni,
    .cap_i   (capture),
    .cap_d_i (cap_d),
    .load_i  (wr_shift),
    .xor_i   (wr_xor),
    .rot_i   (rd_en_i && !running && addr_i == A_DATA),
    .word_i  (wdata_i),
    .q_o     (state_q)
  );

  aes_fe_shreg #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_keyl (
    .clk_i, .rst_ni,
    .cap_i('0), .cap_d_i('0), .xor_i('0), .rot_i('0),
    .load_i (wr_ok && addr_i == A_KEYL),
    .word_i (wdata_i),
    .q_o    (keyl_q)
  );

  aes_fe_shreg #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_keyh (
    .clk_i, .rst_ni,
    .cap_i('0), .cap_d_i('0), .xor_i('0), .rot_i('0),
    .load_i (wr_ok && addr_i == A_KEYH),
    .word_i (wdata_i),
    .q_o    (keyh_q)
  );

  assign eng_state_o        = ctrl_q.byte_rev ? rev_bytes(state_q) : state_q;
  assign eng_key_o[BLK_W-1:0] = ctrl_q.byte_rev ? rev_bytes(keyl_q) : keyl_q;
  assign eng_key_o[2*BLK_W-1:BLK_W] =
      !ctrl_q.key256 ? '0 : (ctrl_q.byte_rev ? rev_bytes(keyh_q) : keyh_q);
  assign eng_decrypt_o = ctrl_q.decrypt;
  assign eng_key256_o  = ctrl_q.key256;
  assign eng_abort_o   = stop;
  assign running_o     = running;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      A_DATA:  rdata_o = state_q[WORD_W-1:0];
      A_STAT:  rdata_o[0] = running;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/aes_fe_chk.sv
module aes_fe_chk
  import aes_fe_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic              running_o,
  input logic              eng_start_o,
  input logic [CTRL_W-1:0] ctrl_q
);
  // R12
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  // R9
  start_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> running_o);

  // R8
  stop_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CMD && wdata_i[1] && running_o) |=> !running_o);

  // R11
  ctrl_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o |=> $stable(ctrl_q));
endmodule

bind aes_reg_frontend aes_fe_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
  .running_o, .eng_start_o, .ctrl_q(ctrl_q)
);

// File: tb/tb_aes_reg_frontend.sv
module tb_aes_reg_frontend;
  import aes_fe_pkg::*;
  localparam int WW = 32, NW = 4, BW = WW * NW, LAT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WW-1:0] wdata = '0, rdata;
  logic running, eng_start, eng_abort, eng_dec, eng_k256, eng_done;
  logic [BW-1:0] eng_state, eng_result;
  logic [2*BW-1:0] eng_key;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  aes_reg_frontend dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .running_o(running),
    .eng_start_o(eng_start), .eng_abort_o(eng_abort), .eng_decrypt_o(eng_dec),
    .eng_key256_o(eng_k256), .eng_state_o(eng_state), .eng_key_o(eng_key),
    .eng_done_i(eng_done), .eng_result_i(eng_result)
  );

  function automatic logic [BW-1:0] mix(logic [BW-1:0] s, logic [2*BW-1:0] k, logic dec);
    logic [BW-1:0] x = s ^ k[BW-1:0] ^ k[2*BW-1:BW];
    return dec ? {x[7:0], x[BW-1:8]} : {x[BW-9:0], x[BW-1:BW-8]};
  endfunction

  function automatic logic [BW-1:0] rev(logic [BW-1:0] x);
    logic [BW-1:0] r;
    for (int i = 0; i < BW / 8; i++) r[8*i +: 8] = x[BW-8-8*i +: 8];
    return r;
  endfunction

  function automatic logic [BW-1:0] expect_res(logic [BW-1:0] s, kl, kh, logic [4:0] c);
    logic br = c[4];
    logic [BW-1:0] ks = br ? rev(kl) : kl;
    logic [BW-1:0] kt = c[1] ? (br ? rev(kh) : kh) : '0;
    logic [BW-1:0] r = mix(br ? rev(s) : s, {kt, ks}, c[0]);
    return br ? rev(r) : r;
  endfunction

  // stub engine: fixed latency
  logic [BW-1:0] s_st;
  logic [2*BW-1:0] s_key;
  logic s_dec;
  int s_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_cnt <= 0;
    else if (eng_start) begin
      s_st <= eng_state; s_key <= eng_key; s_dec <= eng_dec; s_cnt <= LAT;
    end else if (s_cnt != 0) s_cnt <= s_cnt - 1;
  end
  assign eng_done   = (s_cnt == 1);
  assign eng_result = mix(s_st, s_key, s_dec);

  task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [WW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [WW-1:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic load(logic [ADDR_W-1:0] a, logic [BW-1:0] b);
    for (int i = 0; i < NW; i++) wr(a, b[WW*i +: WW]);
  endtask

  task automatic read_blk(output logic [BW-1:0] b);
    for (int i = 0; i < NW; i++) begin
      logic [WW-1:0] w;
      rd(A_DATA, w);
      b[WW*i +: WW] = w;
    end
  endtask

  task automatic wait_idle(output int dur);
    dur = 0;
    while (running && dur < 1000) begin dur++; @(negedge clk); end
  endtask

  task automatic run_op(logic [BW-1:0] s, kl, kh, logic [4:0] c, string req);
    logic [BW-1:0] got;
    int dur;
    wr(A_CTRL, {27'd0, c});
    load(A_KEYL, kl); load(A_KEYH, kh); load(A_DATA, s);
    wr(A_CMD, 32'd1);
    wait_idle(dur);
    read_blk(got);
    check(req, got, expect_res(s, kl, kh, c));
    check({req, " R12 R10 duration"}, BW'(dur), BW'(c[4] ? LAT + 3 : LAT + 1));
  endtask

  function automatic logic [BW-1:0] rnd_blk();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [WW-1:0] w;
    logic [BW-1:0] a, b, kl, kh, got;
    int dur;
    void'($urandom(32'h5eed));
    @(negedge clk); @(negedge clk);
    // R9 reset state
    rd(A_CTRL, w); check("R9 reset ctrl", BW'(w), '0);
    rd(A_STAT, w); check("R9 reset status", BW'(w), '0);
    rd(A_DATA, w); check("R9 reset data", BW'(w), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 ordering and rotation
    a = 128'h33333333_22222222_11111111_00000000;
    load(A_DATA, a);
    read_blk(got); check("R3 read order", got, a);
    read_blk(got); check("R3 rotation restores", got, a);

    // R4 XOR loading
    b = rnd_blk();
    load(A_XOR, b);
    read_blk(got); check("R4 xor load", got, a ^ b);

    // R1 direction, R5 keys, R6 start
    a = rnd_blk(); kl = rnd_blk(); kh = rnd_blk();
    run_op(a, kl, kh, 5'b00000, "R1 R5 R6 encrypt");
    run_op(a, kl, kh, 5'b00001, "R1 decrypt");
    run_op(a, kl, kh, 5'b00010, "R2 R5 key256");
    // R2 high half ignored in 128 mode
    run_op(a, kl, rnd_blk(), 5'b00000, "R2 high half ignored");
    // R10 byte order
    run_op(a, kl, kh, 5'b10011, "R10 byte order");

    // random mix
    for (int i = 0; i < 24; i++)
      run_op(rnd_blk(), rnd_blk(), rnd_blk(), 5'($urandom & 32'h13), "R1 R2 R10 random");

    // R7 auto start on data port
    a = rnd_blk(); kl = rnd_blk();
    wr(A_CTRL, 32'h04);
    load(A_KEYL, kl);
    for (int i = 0; i < NW - 1; i++) wr(A_DATA, a[WW*i +: WW]);
    rd(A_STAT, w); check("R7 no start before fourth", BW'(w), '0);
    wr(A_DATA, a[WW*3 +: WW]);
    rd(A_STAT, w); check("R7 auto start data", BW'(w), 1);
    wait_idle(dur);
    read_blk(got); check("R7 auto result", got, expect_res(a, kl, '0, 5'b00100));

    // R7 port switch restarts count
    wr(A_CTRL, 32'h08);
    wr(A_DATA, 32'h1); wr(A_DATA, 32'h2); wr(A_XOR, 32'h3); wr(A_XOR, 32'h4);
    rd(A_STAT, w); check("R7 switch no start", BW'(w), '0);
    wr(A_XOR, 32'h5); wr(A_XOR, 32'h6);
    rd(A_STAT, w); check("R7 auto start xor", BW'(w), 1);
    wait_idle(dur);

    // R7 auto bit clear
    wr(A_CTRL, 32'h0);
    load(A_DATA, rnd_blk());
    rd(A_STAT, w); check("R7 no auto when clear", BW'(w), '0);

    // R8 stop
    a = rnd_blk();
    load(A_DATA, a);
    wr(A_CMD, 32'd1);
    @(negedge clk);
    wr(A_CMD, 32'd2);
    check("R8 running drops", BW'(running), '0);
    repeat (10) @(negedge clk);
    read_blk(got); check("R8 state kept", got, a);

    // R11 writes ignored while running
    a = rnd_blk(); kl = rnd_blk();
    wr(A_CTRL, 32'h01);
    load(A_KEYL, kl); load(A_DATA, a);
    wr(A_CMD, 32'd1);
    wr(A_CTRL, 32'h1e);
    wr(A_DATA, 32'hdeadbeef);
    wr(A_KEYL, 32'hcafef00d);
    rd(A_DATA, w);
    wait_idle(dur);
    rd(A_CTRL, w); check("R11 ctrl ignored", BW'(w), BW'(1));
    read_blk(got); check("R11 operands frozen", got, expect_res(a, kl, '0, 5'b00001));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule